// File: doc/BRIEF.md
# Branch Target and Link Unit

This block works out where a program goes after a PC-relative conditional branch or a branch-with-link instruction. Each accepted instruction supplies these inputs:

- the current program counter;
- a 4-bit condition field;
- a raw immediate field;
- a flag that tells the short (16-bit) encoding from the long (32-bit) one;
- a pass/fail verdict from an external flag evaluator.

When an instruction is accepted, the block registers the following PC, a link-register write request with its return address, and a sticky error flag. The error flag catches an unconditional branch whose target is its own address.

The immediate is sign-extended from its encoding-dependent width. It is then doubled, so offsets count halfwords. A passed branch adds that offset to the PC, modulo 2^32. A failed branch steps to the next instruction, 2 or 4 bytes on. Condition value 4'b1111 marks branch-with-link. For that value the return address (PC plus instruction size) is sent to the link register whatever the verdict. The block does not evaluate conditions itself, fetch instructions or hold registers.

Top module: `branch_link_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs go to `next_pc`=RESET_PC (default 0), `link_we`=0, `link_data`=0 and `self_branch_err`=0.
- R2: For a short instruction (`is_short`=1) with `cond_pass`=1, `next_pc` becomes `pc` + (sign-extended `imm_raw[7:0]` × 2) one cycle after acceptance. `imm_raw[23:8]` has no effect.
- R3: For a long instruction (`is_short`=0) with `cond_pass`=1, `next_pc` becomes `pc` + (sign-extended `imm_raw[23:0]` × 2) one cycle after acceptance.
- R4: When `cond_pass`=0, `next_pc` becomes `pc`+2 for a short instruction or `pc`+4 for a long one.
- R5: All PC arithmetic wraps modulo 2^32, both forward past 32'hFFFFFFFF and backward below zero.
- R6: An accepted instruction with `cond`=4'b1111 makes `link_we` high for exactly the next cycle, with `link_data` = `pc`+2 (short) or `pc`+4 (long). This holds whether or not the branch passes.
- R7: An accepted instruction with any other `cond` leaves `link_we` low in the next cycle and leaves `link_data` unchanged.
- R8: An accepted instruction with `cond`=4'b0000 whose effective immediate is zero sets `self_branch_err` one cycle later. The effective immediate is `imm_raw[7:0]` for short and `imm_raw[23:0]` for long. The flag then stays high until reset.
- R9: While `inst_valid` is low, `next_pc`, `link_data` and `self_branch_err` keep their values and `link_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid | input | 1 | Instruction accepted this cycle |
| is_short | input | 1 | 1 = 16-bit encoding, 0 = 32-bit encoding |
| cond | input | 4 | Condition field; 4'b1111 = branch-with-link |
| imm_raw | input | 24 | Raw immediate; low 8 bits used for short encoding |
| cond_pass | input | 1 | Condition verdict from external evaluator |
| pc | input | 32 | Address of the current instruction |
| next_pc | output | 32 | Registered next program counter |
| link_we | output | 1 | One-cycle link-register write strobe |
| link_data | output | 32 | Return address for the link register |
| self_branch_err | output | 1 | Sticky unconditional self-branch error |

## Verification
Short and long branches use positive, negative and extreme immediates. This separates the 8-bit from the 24-bit sign extension and exposes a missing halfword shift. Junk in `imm_raw[23:8]` on short instructions shows whether the upper field leaks through. Failed conditions with each size show the two step sizes. PCs near zero and near the top of the address space show wraparound. Link-coded instructions are given both verdicts, and other codes are used to confirm the strobe stays silent. Zero-immediate unconditional branches are tried with each size, next to near-miss immediates whose only set bits lie above bit 7, so the masked zero test is checked exactly. Idle cycles are placed between all of these to confirm the outputs hold.

// File: rtl/blu_pkg.sv
package blu_pkg;
  localparam int unsigned PC_W       = 32;
  localparam int unsigned COND_W     = 4;
  localparam int unsigned SHORT_IMMW = 8;
  localparam int unsigned LONG_IMMW  = 24;
  localparam logic [COND_W-1:0] COND_LINK   = 4'b1111;
  localparam logic [COND_W-1:0] COND_ALWAYS = 4'b0000;
  localparam int unsigned STEP_SHORT = 2;
  localparam int unsigned STEP_LONG  = 4;
endpackage

// File: rtl/blu_offset_gen.sv
module blu_offset_gen #(
  parameter int unsigned SHORT_W = 8,
  parameter int unsigned LONG_W  = 24,
  parameter int unsigned ADDR_W  = 32
) (
  input  logic              is_short,
  input  logic [LONG_W-1:0] imm_raw,
  output logic [ADDR_W-1:0] offset,
  output logic              imm_zero
);
  localparam int unsigned SPAD = ADDR_W - SHORT_W;
  localparam int unsigned LPAD = ADDR_W - LONG_W;

  logic [ADDR_W-1:0] ext_short;
  logic [ADDR_W-1:0] ext_long;

  assign ext_short = {{SPAD{imm_raw[SHORT_W-1]}}, imm_raw[SHORT_W-1:0]};
  assign ext_long  = {{LPAD{imm_raw[LONG_W-1]}},  imm_raw};

  always_comb begin
    if (is_short) begin
      offset   = {ext_short[ADDR_W-2:0], 1'b0};
      imm_zero = (imm_raw[SHORT_W-1:0] == '0);
    end else begin
      offset   = {ext_long[ADDR_W-2:0], 1'b0};
      imm_zero = (imm_raw == '0);
    end
  end
endmodule

// File: rtl/blu_seq_adder.sv
module blu_seq_adder #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned STEP_SMALL = 2,
  parameter int unsigned STEP_LARGE = 4
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              is_short,
  output logic [ADDR_W-1:0] seq_pc
);
  localparam logic [ADDR_W-1:0] INC_S = ADDR_W'(STEP_SMALL);
  localparam logic [ADDR_W-1:0] INC_L = ADDR_W'(STEP_LARGE);
  assign seq_pc = pc + (is_short ? INC_S : INC_L);
endmodule

// File: rtl/branch_link_unit.sv
module branch_link_unit
  import blu_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inst_valid,
  input  logic        is_short,
  input  logic [3:0]  cond,
  input  logic [23:0] imm_raw,
  input  logic        cond_pass,
  input  logic [31:0] pc,
  output logic [31:0] next_pc,
  output logic        link_we,
  output logic [31:0] link_data,
  output logic        self_branch_err
);
  logic [PC_W-1:0] offset;
  logic            imm_zero;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] tgt_pc;
  logic            is_link;
  logic            is_self;

  blu_offset_gen #(.SHORT_W(SHORT_IMMW), .LONG_W(LONG_IMMW), .ADDR_W(PC_W)) u_off (
    .is_short(is_short), .imm_raw(imm_raw), .offset(offset), .imm_zero(imm_zero)
  );

  blu_seq_adder #(.ADDR_W(PC_W), .STEP_SMALL(STEP_SHORT), .STEP_LARGE(STEP_LONG)) u_seq (
    .pc(pc), .is_short(is_short), .seq_pc(seq_pc)
  );

  assign tgt_pc  = pc + offset;
  assign is_link = (cond == COND_LINK);
  assign is_self = (cond == COND_ALWAYS) && imm_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc         <= RESET_PC;
      link_we         <= 1'b0;
      link_data       <= '0;
      self_branch_err <= 1'b0;
    end else begin
      link_we <= inst_valid && is_link;
      if (inst_valid) begin
        next_pc <= cond_pass ? tgt_pc : seq_pc;
        if (is_link) link_data <= seq_pc;
        if (is_self) self_branch_err <= 1'b1;
      end
    end
  end

  p_hold_pc_r9: assert property (@(posedge clk) disable iff (rst)
    !inst_valid |=> $stable(next_pc) && $stable(link_data) && !link_we);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    self_branch_err |=> self_branch_err);
  p_no_link_r7: assert property (@(posedge clk) disable iff (rst)
    (inst_valid && cond != 4'b1111) |=> !link_we && $stable(link_data));
  p_link_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (inst_valid && cond == 4'b1111 && is_short) |=> link_we && link_data == $past(pc) + 32'd2);
  p_notaken_r4: assert property (@(posedge clk) disable iff (rst)
    (inst_valid && !cond_pass && !is_short) |=> next_pc == $past(pc) + 32'd4);
endmodule

// File: tb/tb_branch_link_unit.sv
module tb_branch_link_unit;
  logic        clk = 1'b0;
  logic        rst, inst_valid, is_short, cond_pass;
  logic [3:0]  cond;
  logic [23:0] imm_raw;
  logic [31:0] pc;
  logic [31:0] next_pc, link_data;
  logic        link_we, self_branch_err;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  logic [31:0] e_pc, e_ld;
  logic        e_we, e_err;

  always #5 clk = ~clk;

  branch_link_unit dut (
    .clk(clk), .rst(rst), .inst_valid(inst_valid), .is_short(is_short),
    .cond(cond), .imm_raw(imm_raw), .cond_pass(cond_pass), .pc(pc),
    .next_pc(next_pc), .link_we(link_we), .link_data(link_data),
    .self_branch_err(self_branch_err)
  );

  function automatic logic [31:0] model_off(input logic sh, input logic [23:0] im);
    longint v;
    if (sh) begin
      v = longint'(im[7:0]);
      if (v >= 128) v = v - 256;
    end else begin
      v = longint'(im);
      if (v >= 64'd8388608) v = v - 64'd16777216;
    end
    return 32'(v * 2);
  endfunction

  task automatic compare(input string req);
    total++;
    if (next_pc !== e_pc || link_we !== e_we || link_data !== e_ld || self_branch_err !== e_err) begin
      bad++;
      $display("FAIL %s: actual pc=%h we=%b ld=%h err=%b expected pc=%h we=%b ld=%h err=%b",
               req, next_pc, link_we, link_data, self_branch_err, e_pc, e_we, e_ld, e_err);
    end
  endtask

  // drive at negedge, model updates at posedge, compare at next negedge
  task automatic step(input string req, input logic v, input logic sh, input logic [3:0] c,
                      input logic [23:0] im, input logic cp, input logic [31:0] p);
    logic [31:0] inc;
    inst_valid = v; is_short = sh; cond = c; imm_raw = im; cond_pass = cp; pc = p;
    @(posedge clk);
    inc = sh ? 32'd2 : 32'd4;
    e_we = v && (c == 4'hF);
    if (v) begin
      e_pc = cp ? p + model_off(sh, im) : p + inc;
      if (c == 4'hF) e_ld = p + inc;
      if (c == 4'h0 && (sh ? im[7:0] == 8'h0 : im == 24'h0)) e_err = 1'b1;
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    while (cycles < 20000) begin @(posedge clk); cycles++; end
    bad++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; inst_valid = 0; is_short = 0; cond = 0; imm_raw = 0; cond_pass = 0; pc = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    e_pc = 32'h0; e_we = 0; e_ld = 0; e_err = 0;
    compare("R1");
    rst = 1'b0;
    // R2 short taken, positive / negative / junk upper bits
    step("R2", 1, 1, 4'h3, 24'h00007F, 1, 32'h0000_1000);
    step("R2", 1, 1, 4'h3, 24'h000080, 1, 32'h0000_1000);
    step("R2", 1, 1, 4'h2, 24'hABCDFE, 1, 32'h0000_2000);
    step("R9", 0, 1, 4'hF, 24'h000011, 1, 32'h1234_5678);
    // R3 long taken
    step("R3", 1, 0, 4'h5, 24'h7FFFFF, 1, 32'h0000_0000);
    step("R3", 1, 0, 4'h5, 24'h800000, 1, 32'h4000_0000);
    step("R3", 1, 0, 4'h5, 24'h000100, 1, 32'h0000_0010);
    // R4 not taken
    step("R4", 1, 1, 4'h1, 24'h000044, 0, 32'h0000_0100);
    step("R4", 1, 0, 4'h1, 24'h000044, 0, 32'h0000_0100);
    // R5 wrap
    step("R5", 1, 0, 4'h1, 24'h000000, 0, 32'hFFFF_FFFE);
    step("R5", 1, 1, 4'h1, 24'h0000FE, 1, 32'h0000_0002);
    step("R5", 1, 1, 4'h6, 24'h000010, 1, 32'hFFFF_FFF0);
    // R6 link, both verdicts and sizes
    step("R6", 1, 1, 4'hF, 24'h000010, 1, 32'h0000_3000);
    step("R6", 1, 0, 4'hF, 24'h000010, 0, 32'h0000_4000);
    step("R9", 0, 0, 4'hF, 24'h000010, 1, 32'h0000_5000);
    // R7 other conds leave link alone
    step("R7", 1, 0, 4'hE, 24'h000020, 1, 32'h0000_6000);
    step("R7", 1, 1, 4'h7, 24'h000020, 0, 32'h0000_7000);
    // R8 near misses then hit
    step("R8", 1, 0, 4'h0, 24'h000100, 1, 32'h0000_8000);
    step("R8", 1, 0, 4'h1, 24'h000000, 1, 32'h0000_8000);
    step("R8", 1, 1, 4'h0, 24'h000001, 1, 32'h0000_8000);
    step("R8", 1, 1, 4'h0, 24'hAB0000, 1, 32'h0000_9000);
    step("R8", 1, 0, 4'h4, 24'h000040, 1, 32'h0000_9000);
    step("R9", 0, 0, 4'h0, 24'h000000, 1, 32'h0000_0000);
    step("R8", 1, 0, 4'h2, 24'h000002, 0, 32'h0000_A000);
    // reset clears sticky error
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    e_pc = 32'h0; e_we = 0; e_ld = 0; e_err = 0;
    compare("R1");
    rst = 1'b0;
    step("R8", 1, 0, 4'h0, 24'h000000, 1, 32'h0000_B000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule